// File: doc/BRIEF.md
# Answer-to-Reset Serial Sequencer

This block sends a fixed 32-bit identification stream on a serial data line after a card-style reset. A host raises the reset line, gives at least one serial clock pulse while it is high, and then drops it. The first bit appears once the reset line is low. Each later bit appears after a falling edge of the serial clock. When all 32 bits have been sent, the block releases the line and goes back to standby.

The block runs on a fast system clock that samples the reset and serial clock lines. The design assumes these inputs are already synchronized to that clock. A write-in-progress flag from the memory core blocks the sequence. A new reset pulse in the middle of the stream either restarts the stream from bit 0 or cancels it. The outcome depends on whether a serial clock pulse was seen inside that pulse. The output-enable tells the pad when to drive the data line.

Top module: `atr_sequencer`

## Requirements
- R1: After system reset, and in standby, `sd_oe` is 0 and `sd_out` is 0.
- R2: The stream starts only after a `card_rst` high pulse in which at least one `scl` rising edge was sampled. When `card_rst` falls, `sd_oe` rises and bit 0 is presented one system clock later. A pulse with no `scl` rising edge leaves the block in standby.
- R3: Stream bit n equals bit (n mod 8) of byte n/8, with the bytes in the order 0x19, 0x40, 0xAA, 0x55. Each byte therefore goes out LSB first, and byte 0 reads 1,0,0,1,1,0,0,0.
- R4: While streaming, only an `scl` falling edge moves to the next bit. An `scl` rising edge leaves `sd_out` unchanged.
- R5: The `scl` falling edge that ends bit 31 returns the block to standby.
- R6: If `nv_busy` is 1 in the cycle where `card_rst` is first sampled high, the pulse is ignored and the block stays in, or drops to, standby.
- R7: A mid-stream `card_rst` pulse that contains an `scl` rising edge restarts the stream from bit 0 when `card_rst` falls.
- R8: A mid-stream `card_rst` pulse with no `scl` rising edge aborts to standby when `card_rst` falls. An `scl` rising edge sampled in the same cycle that `card_rst` is low does not count as inside the pulse.
- R9: From the second sampled cycle of a `card_rst` high pulse onward, `sd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous system reset |
| card_rst | input | 1 | Card reset line that requests the stream |
| scl | input | 1 | Serial clock from the host |
| nv_busy | input | 1 | Nonvolatile write in progress |
| sd_out | output | 1 | Serial data bit |
| sd_oe | output | 1 | Drive enable for the data line; 0 means released |

## Verification
Two events can land in the same system cycle: the fall of `card_rst` and an `scl` rising edge. In that case the clock edge must not count as inside the pulse. The bench starts a stream, raises `card_rst` with no clock, and then drops `card_rst` in the same cycle that `scl` rises. It then expects an abort to standby, not a restart from bit 0. Randomly placed restart and abort pulses at random stream depths also exercise how pulse handling interacts with bit advance.

// File: rtl/atr_pkg.sv
package atr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_SEND  = 2'd2
    } atr_state_e;
endpackage

// File: rtl/atr_edge.sv
module atr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/atr_pattern.sv
module atr_pattern #(
    parameter int          BITS = 32,
    parameter logic [BITS-1:0] WORD = 32'h55AA4019,
    localparam int         IDX_W = $clog2(BITS)
) (
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    // Byte k of the stream sits in WORD[8k+7:8k]; bit n of the stream is WORD[n].
    assign bit_o = WORD[idx];
endmodule

// File: rtl/atr_sequencer.sv
module atr_sequencer #(
    parameter int               BITS = 32,
    parameter logic [BITS-1:0]  WORD = 32'h55AA4019
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic scl,
    input  logic nv_busy,
    output logic sd_out,
    output logic sd_oe
);
    import atr_pkg::*;

    localparam int              IDX_W = $clog2(BITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BITS - 1);

    typedef struct packed {
        atr_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             seen_clk;
    } seq_t;

    seq_t seq_d, seq_q;
    logic rst_rise, rst_fall, scl_rise, scl_fall;
    logic pat_bit;

    atr_edge u_rst_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (card_rst),
        .rise (rst_rise),
        .fall (rst_fall)
    );

    atr_edge u_scl_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (scl),
        .rise (scl_rise),
        .fall (scl_fall)
    );

    atr_pattern #(.BITS(BITS), .WORD(WORD)) u_pattern (
        .idx  (seq_q.idx),
        .bit_o(pat_bit)
    );

    always_comb begin
        seq_d = seq_q;
        if (rst_rise) begin
            // A new pulse overrides streaming; a busy core cancels it.
            seq_d.state    = nv_busy ? ST_IDLE : ST_PULSE;
            seq_d.idx      = '0;
            seq_d.seen_clk = 1'b0;
        end else begin
            unique case (seq_q.state)
                ST_PULSE: begin
                    if (card_rst && scl_rise) seq_d.seen_clk = 1'b1;
                    if (rst_fall) begin
                        seq_d.state = seq_q.seen_clk ? ST_SEND : ST_IDLE;
                        seq_d.idx   = '0;
                    end
                end
                ST_SEND: begin
                    if (scl_fall) begin
                        if (seq_q.idx == LAST) begin
                            seq_d.state = ST_IDLE;
                            seq_d.idx   = '0;
                        end else begin
                            seq_d.idx = seq_q.idx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state    <= ST_IDLE;
            seq_q.idx      <= '0;
            seq_q.seen_clk <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sd_oe  = (seq_q.state == ST_SEND);
    assign sd_out = sd_oe & pat_bit;
endmodule

// File: rtl/atr_chk.sv
module atr_chk (
    input logic clk,
    input logic rst_n,
    input logic card_rst,
    input logic scl,
    input logic nv_busy,
    input logic sd_out,
    input logic sd_oe
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out);

    // R9
    pulse_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rst && $past(card_rst)) |-> !sd_oe);

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(card_rst) && nv_busy) |=> !sd_oe);

    // R4
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && !card_rst && !($past(scl) && !scl)) |=> (sd_oe && $stable(sd_out)));

    // R2
    start_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe) |-> (!$past(card_rst) && $past(card_rst, 2) && sd_out));
endmodule

bind atr_sequencer atr_chk u_chk (.*);

// File: tb/sim_atr_sequencer.sv
module sim_atr_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_rst = 1'b0;
    logic scl = 1'b0;
    logic nv_busy = 1'b0;
    logic sd_out, sd_oe;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    atr_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .scl(scl),
        .nv_busy(nv_busy), .sd_out(sd_out), .sd_oe(sd_oe)
    );

    function automatic logic exp_bit(input int n);
        logic [7:0] bytes [4];
        bytes[0] = 8'h19; bytes[1] = 8'h40; bytes[2] = 8'hAA; bytes[3] = 8'h55;
        return bytes[n / 8][n % 8];
    endfunction

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic e_oe, input logic e_out, input string req);
        total++;
        if ({sd_oe, sd_out} !== {e_oe, e_out}) begin
            bad++;
            $display("FAIL %s: got oe=%0b out=%0b expected oe=%0b out=%0b",
                     req, sd_oe, sd_out, e_oe, e_out);
        end
    endtask

    task automatic pulse(input bit with_clk);
        card_rst = 1'b1;
        step(2);
        chk(1'b0, 1'b0, "R9");
        if (with_clk) begin
            scl = 1'b1; step(1);
            scl = 1'b0; step(1);
        end
        card_rst = 1'b0;
        step(1);
    endtask

    // Walk bits first..last-1, checking each bit and its hold on the rising edge.
    task automatic run(input int first, input int last);
        for (int n = first; n < last; n++) begin
            chk(1'b1, exp_bit(n), (n == 0) ? "R2" : "R3");
            scl = 1'b1; step(1);
            chk(1'b1, exp_bit(n), "R4");
            scl = 1'b0; step(1);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        step(4);
        rst_n = 1'b1;
        step(1);
        chk(1'b0, 1'b0, "R1");

        // Pulse with no clock inside: nothing happens
        pulse(1'b0);
        chk(1'b0, 1'b0, "R2");

        // Full stream then standby
        pulse(1'b1);
        run(0, 32);
        chk(1'b0, 1'b0, "R5");

        // Busy core blocks the pulse
        nv_busy = 1'b1;
        pulse(1'b1);
        nv_busy = 1'b0;
        chk(1'b0, 1'b0, "R6");

        // Busy raised mid-stream at the new pulse: drops to standby
        pulse(1'b1);
        run(0, 5);
        nv_busy = 1'b1;
        pulse(1'b1);
        nv_busy = 1'b0;
        chk(1'b0, 1'b0, "R6");

        // Coincident: card_rst falls in the same cycle scl rises -> abort
        pulse(1'b1);
        run(0, 3);
        card_rst = 1'b1;
        step(2);
        card_rst = 1'b0;
        scl = 1'b1;
        step(1);
        chk(1'b0, 1'b0, "R8");
        scl = 1'b0;
        step(1);
        chk(1'b0, 1'b0, "R8");

        // Random depth restart / abort
        for (int t = 0; t < 24; t++) begin
            int k;
            pulse(1'b1);
            k = int'($urandom_range(0, 31));
            run(0, k);
            if ($urandom_range(0, 1) == 1) begin
                pulse(1'b1);
                chk(1'b1, exp_bit(0), "R7");
                run(0, 32);
                chk(1'b0, 1'b0, "R5");
            end else begin
                pulse(1'b0);
                chk(1'b0, 1'b0, "R8");
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no completion expected completion before cycle limit");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule